// File: doc/BRIEF.md
# Stack Call/Return Bus Sequencer

This block generates the cycle-by-cycle bus activity for the four control-flow instructions of an 8-bit processor that use the hardware stack. These are the software break, the subroutine call, the subroutine return and the return from interrupt. A pulse on `start` while the block is idle captures the instruction's opcode, its address, the stack pointer and the status byte. From the next cycle the block drives one bus access per clock. Each access has a 16-bit address, a write strobe and, for writes, the data byte. Read data comes back on `rdata` within the same cycle.

When the last access ends, the block pulses `done` for one cycle. At the same time it presents the next program counter, the final stack pointer and the status byte. The status byte is either the captured value or, on an interrupt return, the byte pulled from the stack. The stack always lives in page one. The 8-bit pointer wraps inside that page.

The sequencer is a single state machine with fourteen named states:

- `ST_IDLE` waits for `start`.
- `ST_FETCH` reads the opcode byte.
- `ST_OPND` reads the byte after the opcode.
- `ST_STK_DUMMY` reads the stack slot without using the data.
- `ST_PUSH_HI`, `ST_PUSH_LO` and `ST_PUSH_ST` are the three stack writes.
- `ST_VEC_LO` and `ST_VEC_HI` fetch the break vector.
- `ST_PULL_ST`, `ST_PULL_LO` and `ST_PULL_HI` are the stack reads.
- `ST_TGT_HI` reads the high byte of the call target.
- `ST_RET_DUMMY` reads the pulled return address and discards the data.

The transitions are:

- `ST_IDLE` goes to `ST_FETCH` on `start`.
- `ST_FETCH` goes to `ST_IDLE` for an unsupported opcode, else to `ST_OPND`.
- `ST_OPND` goes to `ST_PUSH_HI` for a break, else to `ST_STK_DUMMY`.
- `ST_STK_DUMMY` goes to `ST_PUSH_HI` for a call, `ST_PULL_ST` for an interrupt return, or `ST_PULL_LO` for a subroutine return.
- `ST_PUSH_HI` goes to `ST_PUSH_LO`.
- `ST_PUSH_LO` goes to `ST_PUSH_ST` for a break, else to `ST_TGT_HI`.
- `ST_PUSH_ST` goes to `ST_VEC_LO`, and `ST_VEC_LO` goes to `ST_VEC_HI`.
- `ST_PULL_ST` goes to `ST_PULL_LO`, and `ST_PULL_LO` goes to `ST_PULL_HI`.
- `ST_PULL_HI` goes to `ST_RET_DUMMY` for a subroutine return, else to `ST_IDLE`.
- `ST_VEC_HI`, `ST_TGT_HI` and `ST_RET_DUMMY` go to `ST_IDLE`.

Top module: `stack_flow_seq`

## Requirements
- R1: After reset `busy`, `done` and `bus_we` are 0.
- R2: Opcode 0x00 (break) takes 7 bus cycles:
  - reads at PC and PC+1;
  - writes of (PC+2)[15:8] at 0x01:SP, (PC+2)[7:0] at 0x01:SP-1, and the status byte with bit 4 forced to 1 at 0x01:SP-2;
  - reads at 0xFFFE and 0xFFFF.

  The new PC is {byte at 0xFFFF, byte at 0xFFFE} and the final SP is SP-3.
- R3: Opcode 0x20 (call) takes 6 bus cycles:
  - reads at PC and PC+1;
  - a read at 0x01:SP;
  - writes of (PC+2)[15:8] at 0x01:SP and (PC+2)[7:0] at 0x01:SP-1;
  - a read at PC+2.

  The new PC is {byte at PC+2, byte at PC+1} and the final SP is SP-2.
- R4: Opcode 0x60 (subroutine return) takes 6 read cycles, at PC, PC+1, 0x01:SP, 0x01:SP+1, 0x01:SP+2 and then at the pulled address A = {byte at SP+2, byte at SP+1}. The new PC is A+1 and the final SP is SP+2.
- R5: Opcode 0x40 (interrupt return) takes 6 read cycles, at PC, PC+1, 0x01:SP, 0x01:SP+1, 0x01:SP+2 and 0x01:SP+3. The status output becomes the byte at SP+1, the new PC is {byte at SP+3, byte at SP+2} and the final SP is SP+3.
- R6: Every stack access has address high byte 0x01, and its low byte and the final SP wrap modulo 256. PC-relative addresses wrap modulo 65536.
- R7: `busy` is high for exactly the instruction's bus cycles. `done` is high for exactly the one cycle after the last of them, with `pc_out`, `sp_out` and `status_out` valid from that cycle on.
- R8: `start` and the instruction inputs are ignored while `busy` is high. The running sequence and its results are unaffected.
- R9: Any other opcode produces one read at PC and then `done`, with `pc_out` = PC, `sp_out` = SP and `status_out` = the captured status.
- R10: `bus_we` is 1 only in push cycles. For calls and breaks the status output equals the captured status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Opcode of the instruction |
| pc_in | input | 16 | Address of the opcode byte |
| sp_in | input | 8 | Stack pointer at instruction start |
| status_in | input | 8 | Status byte at instruction start |
| rdata | input | 8 | Read data for the current bus address |
| bus_addr | output | 16 | Address of the current bus cycle |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read |
| bus_wdata | output | 8 | Data for a write cycle, 0 otherwise |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Next program counter |
| sp_out | output | 8 | Stack pointer after the instruction |
| status_out | output | 8 | Status byte after the instruction |

## Verification
The bench sweeps all four opcodes and one unsupported opcode over stack pointers at and next to both page edges, and over program counters near 0xFFFF. It compares every bus cycle with an address list computed from the requirements. A design that decrements before pushing, or that wraps into page two, would show a wrong address at SP 0x00 or 0xFF. A design that forgets the +1 on the subroutine return, or swaps the byte order, would show a wrong `pc_out`. A run that holds `start` high with a different opcode throughout the sequence checks that a design restarting mid-instruction is caught.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPND,
        ST_STK_DUMMY,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_PULL_ST,
        ST_PULL_LO,
        ST_PULL_HI,
        ST_TGT_HI,
        ST_RET_DUMMY
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_BRK,
        K_CALL,
        K_RTI,
        K_RET
    } op_kind_e;

    localparam logic [7:0] OPC_BRK  = 8'h00;
    localparam logic [7:0] OPC_CALL = 8'h20;
    localparam logic [7:0] OPC_RTI  = 8'h40;
    localparam logic [7:0] OPC_RET  = 8'h60;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output op_kind_e        kind
);

    always_comb begin
        case (opcode)
            OPC_BRK:  kind = K_BRK;
            OPC_CALL: kind = K_CALL;
            OPC_RTI:  kind = K_RTI;
            OPC_RET:  kind = K_RET;
            default:  kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  op_kind_e   kind_q,
    output seq_state_e state,
    output logic       fin
);

    seq_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_FETCH;
            ST_FETCH:     nxt = (kind_q == K_NONE) ? ST_IDLE : ST_OPND;
            ST_OPND:      nxt = (kind_q == K_BRK) ? ST_PUSH_HI : ST_STK_DUMMY;
            ST_STK_DUMMY: begin
                if (kind_q == K_CALL)     nxt = ST_PUSH_HI;
                else if (kind_q == K_RTI) nxt = ST_PULL_ST;
                else                      nxt = ST_PULL_LO;
            end
            ST_PUSH_HI:   nxt = ST_PUSH_LO;
            ST_PUSH_LO:   nxt = (kind_q == K_BRK) ? ST_PUSH_ST : ST_TGT_HI;
            ST_PUSH_ST:   nxt = ST_VEC_LO;
            ST_VEC_LO:    nxt = ST_VEC_HI;
            ST_VEC_HI:    nxt = ST_IDLE;
            ST_PULL_ST:   nxt = ST_PULL_LO;
            ST_PULL_LO:   nxt = ST_PULL_HI;
            ST_PULL_HI:   nxt = (kind_q == K_RET) ? ST_RET_DUMMY : ST_IDLE;
            ST_TGT_HI:    nxt = ST_IDLE;
            ST_RET_DUMMY: nxt = ST_IDLE;
        endcase
    end

    assign fin = (state != ST_IDLE) && (nxt == ST_IDLE);

endmodule

// File: rtl/stk_busgen.sv
module stk_busgen
    import stk_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
    parameter logic [7:0]  BRK_MASK   = 8'h10
) (
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [DATA_W-1:0] sp_q,
    input  logic [DATA_W-1:0] st_q,
    input  logic [DATA_W-1:0] lo_q,
    input  logic [DATA_W-1:0] hi_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata
);

    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] stk_here;
    logic [ADDR_W-1:0] stk_above;

    assign ret_addr  = ADDR_W'(pc_q + ADDR_W'(2));
    assign stk_here  = {STACK_PAGE, sp_q};
    assign stk_above = {STACK_PAGE, DATA_W'(sp_q + DATA_W'(1))};

    // Output process: one bus cycle per state
    always_comb begin
        bus_addr  = pc_q;
        bus_we    = 1'b0;
        bus_wdata = '0;
        unique case (state)
            ST_IDLE:      bus_addr = pc_q;
            ST_FETCH:     bus_addr = pc_q;
            ST_OPND:      bus_addr = ADDR_W'(pc_q + ADDR_W'(1));
            ST_STK_DUMMY: bus_addr = stk_here;
            ST_PUSH_HI: begin
                bus_addr  = stk_here;
                bus_we    = 1'b1;
                bus_wdata = ret_addr[ADDR_W-1 -: DATA_W];
            end
            ST_PUSH_LO: begin
                bus_addr  = stk_here;
                bus_we    = 1'b1;
                bus_wdata = ret_addr[DATA_W-1:0];
            end
            ST_PUSH_ST: begin
                bus_addr  = stk_here;
                bus_we    = 1'b1;
                bus_wdata = st_q | BRK_MASK;
            end
            ST_VEC_LO:    bus_addr = VEC_ADDR;
            ST_VEC_HI:    bus_addr = ADDR_W'(VEC_ADDR + ADDR_W'(1));
            ST_PULL_ST:   bus_addr = stk_above;
            ST_PULL_LO:   bus_addr = stk_above;
            ST_PULL_HI:   bus_addr = stk_above;
            ST_TGT_HI:    bus_addr = ret_addr;
            ST_RET_DUMMY: bus_addr = {hi_q, lo_q};
        endcase
    end

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  op_kind_e          kind_dec,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata,
    input  seq_state_e        state,
    input  logic              fin,
    output op_kind_e          kind_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] st_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q,
    output logic [ADDR_W-1:0] pc_res,
    output logic [DATA_W-1:0] sp_res,
    output logic [DATA_W-1:0] st_res,
    output logic              done_q
);

    logic [DATA_W-1:0] sp_nxt;
    logic [DATA_W-1:0] st_nxt;
    logic [ADDR_W-1:0] pc_fin;

    always_comb begin
        sp_nxt = sp_q;
        st_nxt = st_q;
        unique case (state)
            ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST:
                sp_nxt = DATA_W'(sp_q - DATA_W'(1));
            ST_PULL_LO, ST_PULL_HI:
                sp_nxt = DATA_W'(sp_q + DATA_W'(1));
            ST_PULL_ST: begin
                sp_nxt = DATA_W'(sp_q + DATA_W'(1));
                st_nxt = rdata;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_VEC_HI, ST_TGT_HI, ST_PULL_HI: pc_fin = {rdata, lo_q};
            ST_RET_DUMMY: pc_fin = ADDR_W'({hi_q, lo_q} + ADDR_W'(1));
            default:      pc_fin = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_NONE;
            pc_q   <= '0;
            sp_q   <= '0;
            st_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pc_res <= '0;
            sp_res <= '0;
            st_res <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (take) begin
                kind_q <= kind_dec;
                pc_q   <= pc_in;
                sp_q   <= sp_in;
                st_q   <= status_in;
            end else begin
                sp_q <= sp_nxt;
                st_q <= st_nxt;
                unique case (state)
                    ST_OPND, ST_PULL_LO, ST_VEC_LO: lo_q <= rdata;
                    ST_PULL_HI, ST_VEC_HI, ST_TGT_HI: hi_q <= rdata;
                    default: ;
                endcase
            end
            if (fin) begin
                pc_res <= pc_fin;
                sp_res <= sp_nxt;
                st_res <= st_nxt;
            end
        end
    end

endmodule

// File: rtl/stack_flow_seq.sv
module stack_flow_seq
    import stk_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
    parameter logic [7:0]  BRK_MASK   = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] opcode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] status_out
);

    seq_state_e        state;
    logic              fin;
    logic              take;
    op_kind_e          kind_dec;
    op_kind_e          kind_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] st_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;

    assign take = start && (state == ST_IDLE);
    assign busy = (state != ST_IDLE);

    stk_decode #(.OP_W(DATA_W)) u_dec (
        .opcode (opcode),
        .kind   (kind_dec)
    );

    stk_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .kind_q (kind_q),
        .state  (state),
        .fin    (fin)
    );

    stk_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .kind_dec  (kind_dec),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .status_in (status_in),
        .rdata     (rdata),
        .state     (state),
        .fin       (fin),
        .kind_q    (kind_q),
        .pc_q      (pc_q),
        .sp_q      (sp_q),
        .st_q      (st_q),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .pc_res    (pc_out),
        .sp_res    (sp_out),
        .st_res    (status_out),
        .done_q    (done)
    );

    stk_busgen #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE),
        .VEC_ADDR   (VEC_ADDR),
        .BRK_MASK   (BRK_MASK)
    ) u_bus (
        .state     (state),
        .pc_q      (pc_q),
        .sp_q      (sp_q),
        .st_q      (st_q),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/stack_flow_chk.sv
module stack_flow_chk
    import stk_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         DATA_W     = 8,
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input seq_state_e        state,
    input logic [DATA_W-1:0] sp_q
);

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_we);

    a_r6_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr[ADDR_W-1 -: 8] == STACK_PAGE));

    a_r6_push_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (sp_q == DATA_W'($past(sp_q) - DATA_W'(1))));

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_brk_bit_pushed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_ST) |-> (bus_we && bus_wdata[4]));

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && $past(rst_n)) |-> (state == ST_FETCH));

endmodule

bind stack_flow_seq stack_flow_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .state     (state),
    .sp_q      (sp_q)
);

// File: tb/test_stack_flow_seq.sv
module test_stack_flow_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  sp_in = 8'h00;
    logic [7:0]  status_in = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic        busy;
    logic        done;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic [7:0]  status_out;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h3C;
    endfunction

    assign rdata = mem_byte(bus_addr);

    stack_flow_seq i_stack_flow_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode),
        .pc_in      (pc_in),
        .sp_in      (sp_in),
        .status_in  (status_in),
        .rdata      (rdata),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .done       (done),
        .pc_out     (pc_out),
        .sp_out     (sp_out),
        .status_out (status_out)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
                          input logic [7:0] sp, input logic [7:0] st,
                          input bit hammer);
        logic [15:0] ea [0:7];
        logic        ew [0:7];
        logic [7:0]  ed [0:7];
        bit          es [0:7];
        int          n;
        logic [15:0] pc2, ret, pc_e;
        logic [7:0]  sp_e, st_e;
        string       req;
        pc2 = 16'(pc + 16'd2);
        for (int i = 0; i < 8; i++) begin
            ew[i] = 1'b0; ed[i] = 8'h00; es[i] = 1'b0; ea[i] = 16'h0000;
        end
        ea[0] = pc;
        ea[1] = 16'(pc + 16'd1);
        st_e = st;
        case (op)
            8'h00: begin
                req = "R2"; n = 7;
                ea[2] = {8'h01, sp}; ea[3] = {8'h01, 8'(sp - 8'd1)}; ea[4] = {8'h01, 8'(sp - 8'd2)};
                ew[2] = 1; ew[3] = 1; ew[4] = 1; es[2] = 1; es[3] = 1; es[4] = 1;
                ed[2] = pc2[15:8]; ed[3] = pc2[7:0]; ed[4] = st | 8'h10;
                ea[5] = 16'hFFFE; ea[6] = 16'hFFFF;
                pc_e = {mem_byte(16'hFFFF), mem_byte(16'hFFFE)};
                sp_e = 8'(sp - 8'd3);
            end
            8'h20: begin
                req = "R3"; n = 6;
                ea[2] = {8'h01, sp}; ea[3] = {8'h01, sp}; ea[4] = {8'h01, 8'(sp - 8'd1)};
                es[2] = 1; es[3] = 1; es[4] = 1; ew[3] = 1; ew[4] = 1;
                ed[3] = pc2[15:8]; ed[4] = pc2[7:0];
                ea[5] = pc2;
                pc_e = {mem_byte(pc2), mem_byte(16'(pc + 16'd1))};
                sp_e = 8'(sp - 8'd2);
            end
            8'h40: begin
                req = "R5"; n = 6;
                for (int i = 0; i < 4; i++) begin
                    ea[2+i] = {8'h01, 8'(sp + 8'(i))}; es[2+i] = 1;
                end
                st_e = mem_byte(ea[3]);
                pc_e = {mem_byte(ea[5]), mem_byte(ea[4])};
                sp_e = 8'(sp + 8'd3);
            end
            8'h60: begin
                req = "R4"; n = 6;
                for (int i = 0; i < 3; i++) begin
                    ea[2+i] = {8'h01, 8'(sp + 8'(i))}; es[2+i] = 1;
                end
                ret = {mem_byte(ea[4]), mem_byte(ea[3])};
                ea[5] = ret;
                pc_e = 16'(ret + 16'd1);
                sp_e = 8'(sp + 8'd2);
            end
            default: begin
                req = "R9"; n = 1;
                pc_e = pc; sp_e = sp;
            end
        endcase
        if (hammer) req = {req, "/R8"};

        @(negedge clk);
        start = 1'b1; opcode = op; pc_in = pc; sp_in = sp; status_in = st;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (hammer) begin
                start = 1'b1; opcode = 8'h60; pc_in = 16'hBEEF;
                sp_in = ~sp; status_in = ~st;
            end else begin
                start = 1'b0;
            end
            check_eq("R7", $sformatf("busy op=%h cyc=%0d", op, k), 32'(busy), 32'd1);
            check_eq(es[k] ? "R6" : req, $sformatf("addr op=%h pc=%h sp=%h cyc=%0d", op, pc, sp, k),
                     32'(bus_addr), 32'(ea[k]));
            check_eq("R10", $sformatf("we op=%h cyc=%0d", op, k), 32'(bus_we), 32'(ew[k]));
            if (ew[k])
                check_eq(req, $sformatf("wdata op=%h cyc=%0d", op, k), 32'(bus_wdata), 32'(ed[k]));
        end
        @(negedge clk);
        start = 1'b0;
        check_eq("R7", $sformatf("done op=%h", op), 32'(done), 32'd1);
        check_eq("R7", $sformatf("idle op=%h", op), 32'(busy), 32'd0);
        check_eq(req, $sformatf("pc_out op=%h pc=%h sp=%h", op, pc, sp), 32'(pc_out), 32'(pc_e));
        check_eq("R6", $sformatf("sp_out op=%h sp=%h", op, sp), 32'(sp_out), 32'(sp_e));
        check_eq((op == 8'h40) ? "R5" : "R10", $sformatf("status op=%h", op),
                 32'(status_out), 32'(st_e));
        @(negedge clk);
        check_eq("R7", $sformatf("done drop op=%h", op), 32'(done), 32'd0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  ops [0:4];
        logic [15:0] pcs [0:3];
        logic [7:0]  sps [0:6];
        ops = '{8'h00, 8'h20, 8'h40, 8'h60, 8'hEA};
        pcs = '{16'h0400, 16'h12FE, 16'hFFFE, 16'hFFFF};
        sps = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFD, 8'hFE, 8'hFF};

        repeat (3) @(negedge clk);
        check_eq("R1", "busy in reset", 32'(busy), 32'd0);
        check_eq("R1", "done in reset", 32'(done), 32'd0);
        check_eq("R1", "we in reset", 32'(bus_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "busy after reset", 32'(busy), 32'd0);
        check_eq("R1", "we after reset", 32'(bus_we), 32'd0);

        for (int o = 0; o < 5; o++)
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 7; s++)
                    run_op(ops[o], pcs[p], sps[s], 8'(8'h21 + 8'(o * 16 + s)), 1'b0);

        for (int o = 0; o < 5; o++)
            run_op(ops[o], 16'h2345, 8'h01, 8'hC3, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule